// File: doc/BRIEF.md
# Bit-Stream ROM Reader

This block lets a host walk through a packed bit stream held in a ROM that is sixteen bits wide. The host writes a 24-bit byte address (three byte registers: low offset, high offset, bank) and the block converts it into a ROM word address with a banked mirroring rule. It then fetches two consecutive words and presents a 16-bit window whose bit 0 is the bit at the current stream position.

A configuration byte holds a shift count and an auto-advance flag. In manual mode, each configuration write moves the bit pointer forward by the count. In auto mode, every host read of the window's high byte moves the pointer forward after that read. When the pointer crosses a word boundary, the block fetches the next sequential ROM word, and a busy flag covers the fetch. Writing any address register clears the configuration, so auto mode must be set up after the address.

Top module: `bitrd_reader`

## Requirements
- R1: For banks 0x00-0x3F and 0x80-0xBF the ROM word address is ((bank & 0x3F) * 0x8000 + (offset & 0x7FFF)) / 2, so offsets 0x0000-0x7FFF read the same data as 0x8000-0xFFFF.
- R2: For banks 0xC0-0xFF the ROM word address is ((bank & 0x3F) * 0x10000 + offset) / 2. Sequential words wrap within the 21-bit word space.
- R3: Every other bank (0x40-0x7F) reads as bank 0x00, giving the word address (offset & 0x7FFF) / 2.
- R4: The least significant address bit is ignored, so an odd start address gives the same stream as the even address below it.
- R5: A write to the bank register (wr_sel = 2) sets the bit pointer to 0 and raises busy in the next cycle. The block fetches the mapped word and the word after it, and busy falls only after a ROM acknowledge.
- R6: When busy is low, win_data equals bits P to P+15 of the stream, where P is the current bit position and stream bit 16*k+j is bit j of the k-th fetched word.
- R7: The configuration register (wr_sel = 3) holds the shift count in bits 3:0, where 0 means 16, and the auto flag in bit 7. A configuration write with bit 7 clear, while busy is low, advances the pointer by the count.
- R8: While the stored auto flag is set, a pulse on rd_hi advances the pointer by the stored count. A configuration write with bit 7 set does not advance the pointer.
- R9: A write to any of the three address registers (wr_sel = 0, 1, 2) clears the configuration register to zero.
- R10: When an advance crosses a word boundary, the second buffered word becomes the current word, the next sequential ROM word is requested and busy stays high until it arrives. rom_addr is held stable while rom_req waits for rom_ack.
- R11: Advance requests (manual or auto) made while busy is high are dropped.
- R12: A register write in the same cycle as rd_hi takes priority, and that rd_hi pulse is ignored.
- R13: A bank write made while a fetch is outstanding discards the word of that fetch. The block then loads from the new address.
- R14: After reset, busy and rom_req are low and win_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 offset low, 1 offset high, 2 bank (starts a load), 3 configuration |
| wr_data | input | 8 | Host write data |
| rd_hi | input | 1 | Host read of the window's high byte (auto-advance trigger) |
| win_data | output | 16 | Bit window starting at the current position |
| busy | output | 1 | Fetch in progress; window not valid |
| rom_req | output | 1 | ROM word request, held until acknowledged |
| rom_addr | output | 21 | ROM word address |
| rom_ack | input | 1 | ROM data valid, one cycle per request |
| rom_rdata | input | 16 | ROM word data |

## Verification
Two cases put functions in the same cycle. In the first, the host asserts rd_hi together with a configuration write while auto mode is on. The bench judges the result by seeing the window unchanged afterwards, and then by a later read that advances by the newly written count. In the second, a new bank write lands while the load's ROM request is still waiting for its acknowledge, and the bench checks that the window finally shows data from the second address only. The bench also issues a manual advance one cycle after a boundary-crossing advance, while the refill is busy, and requires the window to reflect only the first advance.

// File: rtl/bitrd_pkg.sv
package bitrd_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned PTR_W  = $clog2(WORD_W);
  parameter int unsigned CNT_W  = PTR_W + 1;
  parameter int unsigned ADDR_W = 24;
  parameter int unsigned ROM_AW = 21;
  parameter int unsigned CFG_AUTO = 7;

  typedef enum logic [1:0] {
    SEL_OFF_LO = 2'd0,
    SEL_OFF_HI = 2'd1,
    SEL_BANK   = 2'd2,
    SEL_CFG    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_LOAD0 = 2'd1,
    F_LOAD1 = 2'd2,
    F_NEXT  = 2'd3
  } fetch_st_e;

  // Banked byte address -> ROM word address.
  function automatic logic [ROM_AW-1:0] map_word(input logic [ADDR_W-1:0] a);
    logic [7:0]      bank;
    logic [15:0]     off;
    logic [ROM_AW:0] byte_a;
    bank = a[23:16];
    off  = a[15:0];
    if (bank[7:6] == 2'b11)
      byte_a = {bank[5:0], off};
    else if (!bank[6])
      byte_a = {1'b0, bank[5:0], off[14:0]};
    else
      byte_a = {7'd0, off[14:0]};
    return ROM_AW'(byte_a >> 1);
  endfunction

  // Shift field -> advance amount (zero encodes a full word).
  function automatic logic [CNT_W-1:0] shift_amount(input logic [PTR_W-1:0] field);
    return (field == '0) ? CNT_W'(WORD_W) : {1'b0, field};
  endfunction

  // Window of WORD_W bits starting at ptr inside the word pair.
  function automatic logic [WORD_W-1:0] window_of(input logic [WORD_W-1:0] w_lo,
                                                  input logic [WORD_W-1:0] w_hi,
                                                  input logic [PTR_W-1:0]  ptr);
    return WORD_W'({w_hi, w_lo} >> ptr);
  endfunction
endpackage

// File: rtl/bitrd_regs.sv
module bitrd_regs
  import bitrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_hi,
  input  logic              busy,
  output logic              load_ev,
  output logic [ROM_AW-1:0] load_word,
  output logic              adv_ev,
  output logic [CNT_W-1:0]  adv_amt,
  output logic [7:0]        cfg_q
);
  logic [15:0] off_q;
  logic        man_ev;
  logic        auto_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_OFF_LO: begin off_q[7:0]  <= wr_data; cfg_q <= '0; end
        SEL_OFF_HI: begin off_q[15:8] <= wr_data; cfg_q <= '0; end
        SEL_BANK:   cfg_q <= '0;
        SEL_CFG:    cfg_q <= wr_data;
        default:    cfg_q <= cfg_q;
      endcase
    end
  end

  always_comb begin
    load_ev   = wr_en && (wr_sel == SEL_BANK);
    load_word = map_word({wr_data, off_q});
    man_ev    = wr_en && (wr_sel == SEL_CFG) && !wr_data[CFG_AUTO] && !busy;
    auto_ev   = rd_hi && !wr_en && cfg_q[CFG_AUTO] && !busy;
    adv_ev    = man_ev || auto_ev;
    adv_amt   = shift_amount(man_ev ? wr_data[PTR_W-1:0] : cfg_q[PTR_W-1:0]);
  end
endmodule

// File: rtl/bitrd_fetch.sv
module bitrd_fetch
  import bitrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic [ROM_AW-1:0] load_word,
  input  logic              refill_ev,
  input  logic              rom_ack,
  output logic              rom_req,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              word_ev,
  output logic              word_slot,
  output logic              busy
);
  fetch_st_e         st_q;
  logic [ROM_AW-1:0] addr_q;
  logic [ROM_AW-1:0] pend_addr_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      addr_q      <= '0;
      pend_addr_q <= '0;
      pend_q      <= 1'b0;
    end else if (load_ev) begin
      if (st_q == F_IDLE || rom_ack) begin
        st_q   <= F_LOAD0;
        addr_q <= load_word;
        pend_q <= 1'b0;
      end else begin
        pend_q      <= 1'b1;
        pend_addr_q <= load_word;
      end
    end else if (rom_ack && pend_q) begin
      st_q   <= F_LOAD0;
      addr_q <= pend_addr_q;
      pend_q <= 1'b0;
    end else if (rom_ack) begin
      addr_q <= addr_q + 1'b1;
      st_q   <= (st_q == F_LOAD0) ? F_LOAD1 : F_IDLE;
    end else if (refill_ev && st_q == F_IDLE) begin
      st_q <= F_NEXT;
    end
  end

  always_comb begin
    rom_req   = (st_q != F_IDLE);
    rom_addr  = addr_q;
    busy      = rom_req;
    word_ev   = rom_ack && !load_ev && !pend_q;
    word_slot = (st_q != F_LOAD0);
  end
endmodule

// File: rtl/bitrd_window.sv
module bitrd_window
  import bitrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              adv_ev,
  input  logic [CNT_W-1:0]  adv_amt,
  input  logic              word_ev,
  input  logic              word_slot,
  input  logic [WORD_W-1:0] word_data,
  output logic [WORD_W-1:0] win,
  output logic              refill_ev,
  output logic [PTR_W-1:0]  ptr_q
);
  logic [CNT_W-1:0]  sum;
  logic [WORD_W-1:0] slot_q [2];

  always_comb begin
    sum       = {1'b0, ptr_q} + adv_amt;
    refill_ev = adv_ev && sum[CNT_W-1];
    win       = window_of(slot_q[0], slot_q[1], ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load_ev) ptr_q <= '0;
    else if (adv_ev)  ptr_q <= sum[PTR_W-1:0];
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (word_ev && (word_slot == 1'(s)))
        slot_q[s] <= word_data;
      else if (s == 0 && refill_ev)
        slot_q[s] <= slot_q[1];
    end
  end
endmodule

// File: rtl/bitrd_reader.sv
module bitrd_reader
  import bitrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_hi,
  output logic [WORD_W-1:0] win_data,
  output logic              busy,
  output logic              rom_req,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_ack,
  input  logic [WORD_W-1:0] rom_rdata
);
  logic              load_ev;
  logic [ROM_AW-1:0] load_word;
  logic              adv_ev;
  logic [CNT_W-1:0]  adv_amt;
  logic [7:0]        cfg_q;
  logic              refill_ev;
  logic              word_ev;
  logic              word_slot;
  logic [PTR_W-1:0]  ptr_q;

  bitrd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_hi(rd_hi), .busy(busy), .load_ev(load_ev), .load_word(load_word),
    .adv_ev(adv_ev), .adv_amt(adv_amt), .cfg_q(cfg_q)
  );

  bitrd_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .load_word(load_word),
    .refill_ev(refill_ev), .rom_ack(rom_ack), .rom_req(rom_req), .rom_addr(rom_addr),
    .word_ev(word_ev), .word_slot(word_slot), .busy(busy)
  );

  bitrd_window u_win (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .adv_ev(adv_ev), .adv_amt(adv_amt),
    .word_ev(word_ev), .word_slot(word_slot), .word_data(rom_rdata),
    .win(win_data), .refill_ev(refill_ev), .ptr_q(ptr_q)
  );
endmodule

// File: rtl/bitrd_chk.sv
module bitrd_chk
  import bitrd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              rd_hi,
  input logic              busy,
  input logic              rom_req,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_ack,
  input logic              load_ev,
  input logic              adv_ev,
  input logic              refill_ev,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [7:0]        cfg_q
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack && !load_ev) |=> (rom_req && $stable(rom_addr)));

  assert_refill_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_ev |=> busy);

  assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd3) |=> (cfg_q == 8'd0));

  assert_no_adv_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |-> !busy);

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_hi && wr_sel != 2'd3) |-> !adv_ev);

  assert_load_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (busy && ptr_q == '0));

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rom_ack));
endmodule

bind bitrd_reader bitrd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .rd_hi(rd_hi),
  .busy(busy), .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack),
  .load_ev(load_ev), .adv_ev(adv_ev), .refill_ev(refill_ev), .ptr_q(ptr_q),
  .cfg_q(cfg_q)
);

// File: tb/bitrd_reader_tb.sv
`timescale 1ns/1ps
module bitrd_reader_tb;
  localparam int LAT = 3;
  // {bank, offset, expected word address, shift field, steps}
  localparam logic [55:0] VEC [9] = '{
    {8'h00, 16'h8124, 24'h000092, 4'd5,  4'd6},  // R1
    {8'h00, 16'h0124, 24'h000092, 4'd0,  4'd3},  // R1 mirror
    {8'h01, 16'h8000, 24'h004000, 4'd7,  4'd5},  // R1
    {8'h41, 16'h8246, 24'h000123, 4'd3,  4'd8},  // R3
    {8'hC2, 16'h1234, 24'h01091A, 4'd15, 4'd4},  // R2
    {8'hC2, 16'h1235, 24'h01091A, 4'd1,  4'd5},  // R4
    {8'h83, 16'hFFFE, 24'h00FFFF, 4'd9,  4'd4},  // R1
    {8'hFF, 16'hFFFE, 24'h1FFFFF, 4'd0,  4'd3},  // R2 wrap
    {8'h7F, 16'hC000, 24'h002000, 4'd4,  4'd5}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        rd_hi = 1'b0;
  logic [15:0] win_data;
  logic        busy;
  logic        rom_req;
  logic [20:0] rom_addr;
  logic        rom_ack = 1'b0;
  logic [15:0] rom_rdata = 16'd0;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;
  int          lat_cnt = 0;

  always #2.5 clk = ~clk;

  bitrd_reader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_hi(rd_hi), .win_data(win_data), .busy(busy), .rom_req(rom_req),
    .rom_addr(rom_addr), .rom_ack(rom_ack), .rom_rdata(rom_rdata)
  );

  function automatic logic [15:0] rom_word(input logic [20:0] a);
    logic [15:0] t;
    t = a[15:0] * 16'h9E37;
    return t ^ {a[20:16], 6'h2B, a[4:0]};
  endfunction

  function automatic logic [15:0] exp_win(input logic [20:0] base, input int pos);
    logic [20:0] idx;
    logic [31:0] pair;
    idx  = base + 21'(pos / 16);
    pair = {rom_word(idx + 21'd1), rom_word(idx)};
    return pair[(pos % 16) +: 16];
  endfunction

  // ROM model: fixed latency, one acknowledge per request
  always @(posedge clk) begin
    rom_ack <= 1'b0;
    if (rom_req && !rom_ack) begin
      if (lat_cnt == LAT) begin
        rom_ack   <= 1'b1;
        rom_rdata <= rom_word(rom_addr);
        lat_cnt   <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] bank, input logic [15:0] off);
    wr(2'd0, off[7:0]);
    wr(2'd1, off[15:8]);
    wr(2'd2, bank);
    wait_idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int pos;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    check("R14 busy", {15'd0, busy}, 16'd0);
    check("R14 rom_req", {15'd0, rom_req}, 16'd0);
    check("R14 window", win_data, 16'd0);

    // Table walk: mapping (R1 R2 R3 R4), window (R6), manual advance and refill (R7 R10)
    for (int v = 0; v < 9; v++) begin
      logic [7:0]  bank;
      logic [15:0] off;
      logic [20:0] base;
      logic [3:0]  sh;
      int          steps;
      {bank, off} = VEC[v][55:32];
      base  = VEC[v][28:8];
      sh    = VEC[v][7:4];
      steps = int'(VEC[v][3:0]);
      load(bank, off);
      check($sformatf("R1 R2 R3 R4 R6 map vec %0d", v), win_data, exp_win(base, 0));
      pos = 0;
      for (int s = 0; s < steps; s++) begin
        wr(2'd3, {4'h0, sh});
        wait_idle();
        pos += (sh == 4'd0) ? 16 : int'(sh);
        check($sformatf("R7 R10 R6 vec %0d step %0d", v, s), win_data, exp_win(base, pos));
      end
    end

    // R8 auto mode: config write alone does not move, rd_hi does
    load(8'h00, 16'h8124);
    wr(2'd3, 8'h83);
    wait_idle();
    check("R8 cfg write no advance", win_data, exp_win(21'h92, 0));
    pos = 0;
    for (int s = 0; s < 7; s++) begin
      rd();
      wait_idle();
      pos += 3;
      check($sformatf("R8 auto read %0d", s), win_data, exp_win(21'h92, pos));
    end

    // R12 write and rd_hi in the same cycle: rd_hi ignored
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h85; rd_hi = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_hi = 1'b0;
    wait_idle();
    check("R12 collision no advance", win_data, exp_win(21'h92, pos));
    rd();
    wait_idle();
    pos += 5;
    check("R12 new count used", win_data, exp_win(21'h92, pos));

    // R9 address write clears configuration
    wr(2'd0, 8'h24);
    rd();
    wait_idle();
    check("R9 offset write clears auto", win_data, exp_win(21'h92, pos));
    wr(2'd3, 8'h82);
    load(8'h00, 16'h8124);
    rd();
    wait_idle();
    check("R9 bank write clears auto", win_data, exp_win(21'h92, 0));

    // R11 advance during refill dropped; R10 busy during refill
    load(8'h01, 16'h8000);
    wr(2'd3, 8'h00);
    check("R10 busy after crossing", {15'd0, busy}, 16'd1);
    wr(2'd3, 8'h04);
    wait_idle();
    check("R11 busy advance dropped", win_data, exp_win(21'h4000, 16));

    // R13 bank rewrite during outstanding load
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h01);
    check("R5 busy after bank write", {15'd0, busy}, 16'd1);
    wr(2'd2, 8'hC2);
    wait_idle();
    check("R13 reload new address", win_data, exp_win(21'h14000, 0));
    wr(2'd3, 8'h08);
    wait_idle();
    check("R13 stream continues", win_data, exp_win(21'h14000, 8));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule